// File: doc/BRIEF.md
# NAND Packet Data-Port Transfer Engine

This block moves one page of data between a host-visible 32-bit data port and a byte-wide flash-side stream, in packets whose size and number the host programs beforehand. The host writes a packet register (size in bytes and packet count), then writes a trigger bit into a program register to start either a page read or a page program. The engine keeps a single packet-sized buffer and tells the host, once per packet, when it is time to move that packet's words through the data port. A separate completion flag rises only after the final packet has fully moved.

For a read, the engine accepts bytes from the flash-side receive stream until one packet is buffered, then raises a read-ready level. The host drains the packet word by word, and the engine returns to filling. For a program, the engine raises a write-ready level, and the host fills the buffer. The engine then streams the packet's bytes out on the transmit stream. Both flash-side streams use valid/ready handshakes. The receive side stalls the source by holding `rx_ready` low whenever the buffer holds an undrained packet. The transmit side holds `tx_valid` and `tx_data` steady until the sink raises `tx_ready`. Misused data-port accesses are absorbed and recorded in sticky flags.

Top module: `nand_pkt_engine`

## Requirements
- R1: After reset, `busy`, `rd_ready`, `wr_ready`, `xfer_done`, `underflow`, `overflow`, `rx_ready` and `tx_valid` are low, and `host_rdata` is zero.
- R2: A host write to address 0 stores the packet size in bytes from bits 11:0 and the packet count from bits 23:12. Such a write is ignored while `busy` is high.
- R3: A host write to address 1 while idle starts a page read if bit 0 is set, or a page program if bit 4 is set. If both bits are set, bit 0 takes precedence. If neither bit is set, the write has no effect.
- R4: During a read, `rx_ready` is high while the buffer is filling. When the packet's last byte is accepted, `rx_ready` falls and `rd_ready` rises on the next cycle. Bytes are packed little-endian (byte 0 in bits 7:0), and a partial final word has its unused upper bytes set to zero.
- R5: While `rd_ready` is high, each host read of address 2 returns the next packet word on `host_rdata` one cycle later. A packet holds ceil(size/4) words. The buffer is one packet deep: no byte is accepted until the host has drained the whole packet, and only then does filling resume for a non-final packet.
- R6: During a program, `wr_ready` is high until the host has written ceil(size/4) words to address 2. The engine then sends exactly `size` bytes on the transmit stream, little-endian, and `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low.
- R7: `xfer_done` rises, and `busy` falls, on the cycle after the final word is read (for a read) or the final byte is sent (for a program). `xfer_done` stays high until the next accepted trigger. A trigger with a zero size or a zero count completes at once, with no data moved.
- R8: A host read of address 2 while `rd_ready` is low returns zero and sets the sticky `underflow` flag.
- R9: A host write of address 2 while `wr_ready` is low is dropped, and it sets the sticky `overflow` flag. The dropped word never reaches the transmit stream.
- R10: A trigger written while `busy` is high is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 packet register, 1 program register, 2 data port |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Data-port read word, valid the cycle after `host_rd` |
| rx_valid | input | 1 | Flash-side receive byte valid |
| rx_data | input | 8 | Flash-side receive byte |
| rx_ready | output | 1 | Engine can accept a receive byte |
| tx_valid | output | 1 | Flash-side transmit byte valid |
| tx_data | output | 8 | Flash-side transmit byte |
| tx_ready | input | 1 | Sink accepts the transmit byte |
| busy | output | 1 | Transfer in progress |
| rd_ready | output | 1 | A full read packet waits for the host |
| wr_ready | output | 1 | Buffer waits for host write words |
| xfer_done | output | 1 | Final packet has moved |
| underflow | output | 1 | Sticky: data-port read with no packet pending |
| overflow | output | 1 | Sticky: data-port write dropped |

## Verification
Every result is one register away from its cause. A trigger, an accepted final byte, a drained final word or a dropped access changes the status outputs after the very next rising edge. A data-port read word appears on `host_rdata` after that same edge. The bench drives each stimulus at a falling edge and samples at the following falling edge, so each check lands exactly one edge after its cause. Flash-side handshakes are decided from the `rx_ready` and `tx_valid` levels seen at the falling edge, because those levels cannot change before the next rising edge.

// File: rtl/nand_pkt_pkg.sv
package nand_pkt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FILL,
    ST_RD_DRAIN,
    ST_WR_FILL,
    ST_WR_SEND
  } eng_state_t;

  localparam logic [1:0] ADDR_PKT  = 2'd0;
  localparam logic [1:0] ADDR_PROG = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int TRIG_RD_BIT = 0;
  localparam int TRIG_WR_BIT = 4;
  localparam int COUNT_LSB   = 12;
endpackage

// File: rtl/nand_pkt_buf.sv
module nand_pkt_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [31:0]   rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [31:0]   rdata_b
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nand_pkt_packer.sv
module nand_pkt_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic [1:0]  lane,
  input  logic        flush,
  output logic        word_vld,
  output logic [31:0] word_data
);
  logic [31:0] acc_q;

  always_comb begin
    word_data = acc_q;
    word_data[{lane, 3'b000} +: 8] = byte_data;
  end

  assign word_vld = byte_vld && ((lane == 2'd3) || flush);

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (word_vld) acc_q <= '0;
    else if (byte_vld) acc_q <= word_data;
  end

  // R4
  pack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && lane == 2'd0) |-> (acc_q == 32'd0));
endmodule

// File: rtl/nand_pkt_engine.sv
module nand_pkt_engine
  import nand_pkt_pkg::*;
#(
  parameter int MAX_PKT_BYTES = 1024,
  parameter int CNT_W         = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        busy,
  output logic        rd_ready,
  output logic        wr_ready,
  output logic        xfer_done,
  output logic        underflow,
  output logic        overflow
);
  localparam int SIZE_W = COUNT_LSB;
  localparam int WORDS  = MAX_PKT_BYTES / 4;
  localparam int AW     = $clog2(WORDS);

  eng_state_t        state_q;
  logic [SIZE_W-1:0] size_q, byte_idx_q, word_idx_q, nwords;
  logic [CNT_W-1:0]  cnt_q, pkt_idx_q;
  logic              done_q, unf_q, ovf_q;
  logic [31:0]       rdata_q;

  logic pkt_wr, prog_wr, dp_wr, dp_rd, rx_fire, tx_fire;
  logic last_byte, last_word, last_pkt, trig_go;
  logic pk_vld;
  logic [31:0] pk_word, buf_rd_a, buf_rd_b, buf_wdata;
  logic buf_we;
  logic [AW-1:0] buf_waddr;

  always_comb begin
    pkt_wr    = host_wr && host_addr == ADDR_PKT;
    prog_wr   = host_wr && host_addr == ADDR_PROG;
    dp_wr     = host_wr && host_addr == ADDR_DATA;
    dp_rd     = host_rd && host_addr == ADDR_DATA;
    rx_fire   = rx_valid && rx_ready;
    tx_fire   = tx_valid && tx_ready;
    nwords    = (size_q + SIZE_W'(3)) >> 2;
    last_byte = byte_idx_q == size_q - SIZE_W'(1);
    last_word = word_idx_q == nwords - SIZE_W'(1);
    last_pkt  = pkt_idx_q == cnt_q - CNT_W'(1);
    trig_go   = prog_wr && state_q == ST_IDLE &&
                (host_wdata[TRIG_RD_BIT] || host_wdata[TRIG_WR_BIT]);
  end

  assign rx_ready   = state_q == ST_RD_FILL;
  assign tx_valid   = state_q == ST_WR_SEND;
  assign rd_ready   = state_q == ST_RD_DRAIN;
  assign wr_ready   = state_q == ST_WR_FILL;
  assign busy       = state_q != ST_IDLE;
  assign xfer_done  = done_q;
  assign underflow  = unf_q;
  assign overflow   = ovf_q;
  assign host_rdata = rdata_q;

  nand_pkt_packer u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (rx_fire),
    .byte_data (rx_data),
    .lane      (byte_idx_q[1:0]),
    .flush     (last_byte),
    .word_vld  (pk_vld),
    .word_data (pk_word)
  );

  always_comb begin
    if (state_q == ST_RD_FILL) begin
      buf_we    = pk_vld;
      buf_waddr = byte_idx_q[AW+1:2];
      buf_wdata = pk_word;
    end else begin
      buf_we    = dp_wr && state_q == ST_WR_FILL;
      buf_waddr = word_idx_q[AW-1:0];
      buf_wdata = host_wdata;
    end
  end

  nand_pkt_buf #(.DEPTH(WORDS), .AW(AW)) u_buf (
    .clk     (clk),
    .we      (buf_we),
    .waddr   (buf_waddr),
    .wdata   (buf_wdata),
    .raddr_a (word_idx_q[AW-1:0]),
    .rdata_a (buf_rd_a),
    .raddr_b (byte_idx_q[AW+1:2]),
    .rdata_b (buf_rd_b)
  );

  assign tx_data = buf_rd_b[{byte_idx_q[1:0], 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      size_q     <= '0;
      cnt_q      <= '0;
      byte_idx_q <= '0;
      word_idx_q <= '0;
      pkt_idx_q  <= '0;
      done_q     <= 1'b0;
      unf_q      <= 1'b0;
      ovf_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (pkt_wr && state_q == ST_IDLE) begin
        size_q <= host_wdata[SIZE_W-1:0];
        cnt_q  <= host_wdata[COUNT_LSB +: CNT_W];
      end
      if (dp_rd) begin
        rdata_q <= (state_q == ST_RD_DRAIN) ? buf_rd_a : 32'd0;
        if (state_q != ST_RD_DRAIN) unf_q <= 1'b1;
      end
      if (dp_wr && state_q != ST_WR_FILL) ovf_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          if (trig_go) begin
            byte_idx_q <= '0;
            word_idx_q <= '0;
            pkt_idx_q  <= '0;
            if (size_q == '0 || cnt_q == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q  <= 1'b0;
              state_q <= host_wdata[TRIG_RD_BIT] ? ST_RD_FILL : ST_WR_FILL;
            end
          end
        end
        ST_RD_FILL: begin
          if (rx_fire) begin
            byte_idx_q <= last_byte ? '0 : byte_idx_q + SIZE_W'(1);
            if (last_byte) state_q <= ST_RD_DRAIN;
          end
        end
        ST_RD_DRAIN: begin
          if (dp_rd) begin
            word_idx_q <= last_word ? '0 : word_idx_q + SIZE_W'(1);
            if (last_word) begin
              if (last_pkt) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                pkt_idx_q <= pkt_idx_q + CNT_W'(1);
                state_q   <= ST_RD_FILL;
              end
            end
          end
        end
        ST_WR_FILL: begin
          if (dp_wr) begin
            word_idx_q <= last_word ? '0 : word_idx_q + SIZE_W'(1);
            if (last_word) state_q <= ST_WR_SEND;
          end
        end
        ST_WR_SEND: begin
          if (tx_fire) begin
            byte_idx_q <= last_byte ? '0 : byte_idx_q + SIZE_W'(1);
            if (last_byte) begin
              if (last_pkt) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else begin
                pkt_idx_q <= pkt_idx_q + CNT_W'(1);
                state_q   <= ST_WR_FILL;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && wr_ready));
  // R5
  one_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !rx_ready);
  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);
  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R10
  trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_valid && host_wr && host_addr == ADDR_PROG) |=> rx_ready);
endmodule

// File: tb/nand_pkt_engine_test.sv
module nand_pkt_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'd0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic        busy, rd_ready, wr_ready, xfer_done, underflow, overflow;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] src [0:4095];

  always #4 clk = ~clk;

  nand_pkt_engine uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .busy(busy), .rd_ready(rd_ready), .wr_ready(wr_ready),
    .xfer_done(xfer_done), .underflow(underflow), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(int base, int w, int size);
    logic [31:0] r = 32'd0;
    for (int k = 0; k < 4; k++)
      if (w * 4 + k < size) r[k*8 +: 8] = src[base + w*4 + k];
    return r;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic dp_read(output logic [31:0] w);
    @(negedge clk); host_rd = 1'b1; host_addr = 2'd2;
    @(negedge clk); host_rd = 1'b0; w = host_rdata;
  endtask

  task automatic feed(input int base, input int n);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      if ($urandom % 4 == 0) rx_valid = 1'b0;
      else begin
        rx_valid = 1'b1; rx_data = src[base + i];
        if (rx_ready) i++;
      end
    end
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic collect(input int base, input int n, output int bad);
    int i = 0;
    bad = 0;
    while (i < n) begin
      @(negedge clk);
      tx_ready = ($urandom % 3) != 0;
      if (tx_valid && tx_ready) begin
        if (tx_data != src[base + i]) bad++;
        i++;
      end
    end
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic fill_src(input int n);
    for (int i = 0; i < n; i++) src[i] = 8'($urandom);
  endtask

  task automatic run_read(input int size, input int cnt);
    logic [31:0] w;
    int nw = (size + 3) / 4;
    int bad;
    fill_src(size * cnt);
    reg_write(2'd0, (cnt << 12) | size);
    reg_write(2'd1, 32'h1);
    chk(busy && rx_ready && !xfer_done, "R3 read start", {busy, rx_ready, xfer_done}, 3'b110);
    for (int p = 0; p < cnt; p++) begin
      feed(p * size, size);
      chk(rd_ready && !rx_ready, "R4 packet full", {rd_ready, rx_ready}, 2'b10);
      @(negedge clk); rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
      chk(!rx_ready && rd_ready, "R5 one deep", {rx_ready, rd_ready}, 2'b01);
      bad = 0;
      for (int k = 0; k < nw; k++) begin
        dp_read(w);
        if (w !== exp_word(p * size, k, size)) begin
          bad++;
          $display("FAIL R5 word %0d actual=%h expected=%h", k, w, exp_word(p * size, k, size));
        end
      end
      chk(bad == 0, "R5 drained words", bad, 0);
      if (p < cnt - 1)
        chk(rx_ready && !rd_ready, "R5 refill", {rx_ready, rd_ready}, 2'b10);
    end
    chk(xfer_done && !busy, "R7 read done", {xfer_done, busy}, 2'b10);
  endtask

  task automatic run_write(input int size, input int cnt, input bit poke);
    int nw = (size + 3) / 4;
    int bad;
    fill_src(size * cnt + 4);
    reg_write(2'd0, (cnt << 12) | size);
    reg_write(2'd1, 32'h10);
    for (int p = 0; p < cnt; p++) begin
      chk(wr_ready && busy, "R6 write ready", {wr_ready, busy}, 2'b11);
      for (int k = 0; k < nw; k++) reg_write(2'd2, exp_word(p * size, k, size));
      chk(!wr_ready && tx_valid, "R6 send start", {wr_ready, tx_valid}, 2'b01);
      if (poke) begin
        reg_write(2'd2, 32'hDEADBEEF);
        chk(overflow, "R9 overflow set", overflow, 1);
      end
      collect(p * size, size, bad);
      chk(bad == 0, "R6 byte stream", bad, 0);
    end
    chk(xfer_done && !busy && !tx_valid, "R7 write done", {xfer_done, busy, tx_valid}, 3'b100);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({busy, rd_ready, wr_ready, xfer_done, underflow, overflow, rx_ready, tx_valid} == 8'd0,
        "R1 reset flags", {busy, rd_ready, wr_ready, xfer_done, underflow, overflow, rx_ready, tx_valid}, 0);
    chk(host_rdata == 32'd0, "R1 reset rdata", host_rdata, 0);

    // R3 trigger without a start bit has no effect
    reg_write(2'd0, (1 << 12) | 8);
    reg_write(2'd1, 32'h4);
    chk(!busy && !rx_ready && !wr_ready, "R3 no start bit", busy, 0);

    // R4 ID-sized and status-sized reads
    run_read(8, 1);
    chk(xfer_done, "R7 done holds", xfer_done, 1);
    run_read(1, 1);
    run_read(5, 2);

    // R2 and R10: config and trigger writes during a read are ignored
    fill_src(8);
    reg_write(2'd0, (1 << 12) | 8);
    reg_write(2'd1, 32'h1);
    chk(!xfer_done, "R7 done cleared by trigger", xfer_done, 0);
    reg_write(2'd0, (1 << 12) | 4);
    reg_write(2'd1, 32'h10);
    chk(rx_ready && !wr_ready, "R10 trigger ignored", {rx_ready, wr_ready}, 2'b10);
    feed(0, 4);
    chk(!rd_ready && rx_ready, "R2 size kept while busy", {rd_ready, rx_ready}, 2'b01);
    feed(4, 4);
    chk(rd_ready, "R2 full after 8 bytes", rd_ready, 1);
    dp_read(w); chk(w == exp_word(0, 0, 8), "R2 word0", w, exp_word(0, 0, 8));
    dp_read(w); chk(w == exp_word(0, 1, 8), "R2 word1", w, exp_word(0, 1, 8));
    chk(xfer_done, "R7 done after drain", xfer_done, 1);

    // R3 both bits set: read wins
    fill_src(8);
    reg_write(2'd1, 32'h11);
    chk(rx_ready && !wr_ready, "R3 read priority", {rx_ready, wr_ready}, 2'b10);
    feed(0, 8);
    dp_read(w); dp_read(w);
    chk(w == exp_word(0, 1, 8) && xfer_done, "R3 priority read data", w, exp_word(0, 1, 8));

    // R7 zero count completes at once
    reg_write(2'd0, (0 << 12) | 8);
    reg_write(2'd1, 32'h1);
    chk(xfer_done && !busy, "R7 zero count", {xfer_done, busy}, 2'b10);

    // R6 writes, R9 overflow while sending
    run_write(8, 2, 1'b0);
    chk(!overflow, "R9 no overflow yet", overflow, 0);
    run_write(8, 1, 1'b1);
    run_write(3, 1, 1'b0);

    // random mix
    for (int it = 0; it < 6; it++) begin
      int sz = ($urandom % 2) ? 4 * (1 + $urandom % 16) : 1 + $urandom % 64;
      int ct = 1 + $urandom % 3;
      run_read(sz, ct);
      run_write(sz, ct, 1'b0);
    end

    // large packets
    run_read(1024, 1);
    run_write(512, 2, 1'b0);

    // R8 underflow in idle
    chk(!underflow, "R8 no underflow yet", underflow, 0);
    dp_read(w);
    chk(w == 32'd0 && underflow, "R8 underflow read", {w[30:0], underflow}, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule